// File: doc/BRIEF.md
# Programmable Wait-State Ready Generator

This block produces the address-phase and data-phase ready handshakes for a 16-bit multiplexed bus. It stretches each phase by a programmed number of clock cycles, so that memories and I/O devices of several speeds can share one bus. The address space is divided into four equal quarters. Memory cycles and I/O cycles each have their own table of 4-bit wait counts, one count per quarter.

For slow peripherals that answer only after milliseconds, two address windows can be switched into a long mode. In long mode the wait count is measured in pulses of an externally supplied millisecond tick instead of clock cycles. An external hold input can pull the data-ready output low at any time. The bus sequencer latches the address and drives the strobes. It reads the two ready outputs and writes the three configuration registers through a simple write port.

Top module: `waitReadyGen`

## Requirements
- R1: After reset, both wait tables read as FFFF (every quarter waits 15), all control bits are 0 and the address-phase wait is 3.
- R2: `addrReady` is low in the first cycle in which `addrStrobe` is high and stays low for exactly the programmed address wait (0 to 3 clocks). It is then high until the strobe drops, and it is low whenever the strobe is low. The address wait is control bits [4:3].
- R3: For a memory cycle, the wait count is the 4-bit field at bits [4q+3:4q] of the memory table (register select 0), where q is address bits [15:14].
- R4: In normal mode, `dataReady` is low for exactly N clocks starting with the first cycle in which `dataStrobe` is high, where N is the selected count. It is then high until the strobe drops, and it is low whenever the strobe is low. N = 0 gives ready in the first strobe cycle.
- R5: For an I/O cycle with control bit 0 clear, only addresses whose bits [13:8] are zero use the I/O table (register select 1) field q. All other I/O addresses get zero wait.
- R6: With control bit 0 set, every I/O address uses I/O table field q.
- R7: With control bit 1 set, memory addresses 0000-3FFF are in long mode. The count is the number of `msTick` pulses, sampled in the cycles after the first strobe cycle, that must pass before `dataReady` rises. A field of 0 gives zero wait.
- R8: With control bit 2 set, I/O addresses 0000-00FF and 8000-80FF are in long mode, counted as in R7, using I/O field 0 or 2. Other I/O addresses keep normal timing.
- R9: While `extHold` is 1, `dataReady` is 0. The wait count keeps running while held, and ready returns as soon as the hold drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrPage | input | 8 | Upper byte (bits 15:8) of the latched bus address |
| isMem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| addrStrobe | input | 1 | Address strobe, active high |
| dataStrobe | input | 1 | Data strobe, active high |
| extHold | input | 1 | External override; 1 forces dataReady low |
| msTick | input | 1 | One-clock pulse per millisecond |
| regWe | input | 1 | Register write enable |
| regSel | input | 2 | 0 memory table, 1 I/O table, 2 control (bit0 full I/O span, bit1 long memory, bit2 long I/O, bits 4:3 address wait) |
| regWdata | input | 16 | Register write data |
| addrReady | output | 1 | Address-phase ready |
| dataReady | output | 1 | Data-phase ready |

## Verification
The checker watches every cycle for three things. Neither ready output may be high without its strobe. `dataReady` must stay low while the hold is active. Once a ready output has risen, it must stay high for the rest of its strobe. These properties cannot tell whether the number of wait cycles is correct. Only the bench's sweeps show that. They cover the quarter-to-field mapping, the I/O window and full-span variants, the long-mode tick counting and the reset contents, and they measure the low time of each strobe against an expected value computed arithmetically.

// File: rtl/waitReadyPkg.sv
package waitReadyPkg;
  typedef struct packed {
    logic addrStart;
    logic dataStart;
    logic addrActive;
    logic dataActive;
  } strbCmd_t;
endpackage

// File: rtl/waitReadyCtrl.sv
module waitReadyCtrl
  import waitReadyPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     addrStrobe,
  input  logic     dataStrobe,
  output strbCmd_t cmd
);
  logic addrPrev;
  logic dataPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrPrev <= 1'b0;
      dataPrev <= 1'b0;
    end else begin
      addrPrev <= addrStrobe;
      dataPrev <= dataStrobe;
    end
  end

  // A strobe begins in the first cycle it is seen high.
  always_comb begin
    cmd.addrStart  = addrStrobe && !addrPrev;
    cmd.dataStart  = dataStrobe && !dataPrev;
    cmd.addrActive = addrStrobe;
    cmd.dataActive = dataStrobe;
  end
endmodule

// File: rtl/waitReadyPath.sv
module waitReadyPath
  import waitReadyPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int FIELD_W = 4,
  parameter int REGIONS = 4,
  parameter int AWAIT_W = 2,
  parameter int WIN_W   = 8,
  localparam int SEL_W   = $clog2(REGIONS),
  localparam int TABLE_W = FIELD_W * REGIONS,
  localparam int PAGE_W  = ADDR_W - WIN_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strbCmd_t           cmd,
  input  logic [PAGE_W-1:0]  addrPage,
  input  logic               isMem,
  input  logic               extHold,
  input  logic               msTick,
  input  logic               regWe,
  input  logic [1:0]         regSel,
  input  logic [TABLE_W-1:0] regWdata,
  output logic               addrReady,
  output logic               dataReady
);
  localparam int CTRL_W = 3 + AWAIT_W;

  logic [TABLE_W-1:0] memTable;
  logic [TABLE_W-1:0] ioTable;
  logic               fullIoSpan;
  logic               longMemEn;
  logic               longIoEn;
  logic [AWAIT_W-1:0] addrWait;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memTable   <= '1;
      ioTable    <= '1;
      fullIoSpan <= 1'b0;
      longMemEn  <= 1'b0;
      longIoEn   <= 1'b0;
      addrWait   <= '1;
    end else if (regWe) begin
      case (regSel)
        2'd0: memTable <= regWdata;
        2'd1: ioTable  <= regWdata;
        2'd2: {addrWait, longIoEn, longMemEn, fullIoSpan} <= regWdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  // Field selection by address quarter.
  logic [SEL_W-1:0]   region;
  logic [FIELD_W-1:0] memField;
  logic [FIELD_W-1:0] ioField;
  logic               ioInWindow;
  logic               longIoHit;
  logic               useLong;
  logic [FIELD_W-1:0] selField;

  always_comb begin
    region     = addrPage[PAGE_W-1 -: SEL_W];
    memField   = memTable[region*FIELD_W +: FIELD_W];
    ioField    = ioTable[region*FIELD_W +: FIELD_W];
    ioInWindow = fullIoSpan || (addrPage[PAGE_W-SEL_W-1:0] == '0);
    longIoHit  = (addrPage[PAGE_W-2:0] == '0);
    if (isMem) begin
      selField = memField;
      useLong  = longMemEn && (region == '0);
    end else begin
      selField = ioInWindow ? ioField : '0;
      useLong  = longIoEn && longIoHit;
    end
  end

  // Address-phase wait counter (clock cycles only).
  logic [AWAIT_W-1:0] addrCnt;
  logic [AWAIT_W-1:0] addrRemain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrCnt <= '0;
    else if (cmd.addrStart) addrCnt <= (addrWait == '0) ? '0 : addrWait - AWAIT_W'(1);
    else if (addrCnt != '0) addrCnt <= addrCnt - AWAIT_W'(1);
  end

  assign addrRemain = cmd.addrStart ? addrWait : addrCnt;
  assign addrReady  = cmd.addrActive && (addrRemain == '0);

  // Data-phase wait counter (clocks or millisecond ticks).
  logic [FIELD_W-1:0] dataCnt;
  logic               dataLong;
  logic [FIELD_W-1:0] dataRemain;
  logic               dataStep;

  assign dataStep = dataLong ? msTick : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataCnt  <= '0;
      dataLong <= 1'b0;
    end else if (cmd.dataStart) begin
      dataLong <= useLong;
      if (useLong)              dataCnt <= selField;
      else if (selField == '0)  dataCnt <= '0;
      else                      dataCnt <= selField - FIELD_W'(1);
    end else if (dataCnt != '0 && dataStep) begin
      dataCnt <= dataCnt - FIELD_W'(1);
    end
  end

  assign dataRemain = cmd.dataStart ? selField : dataCnt;
  assign dataReady  = cmd.dataActive && (dataRemain == '0) && !extHold;
endmodule

// File: rtl/waitReadyGen.sv
module waitReadyGen
  import waitReadyPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int FIELD_W = 4,
  parameter int REGIONS = 4,
  parameter int AWAIT_W = 2,
  parameter int WIN_W   = 8,
  localparam int TABLE_W = FIELD_W * REGIONS,
  localparam int PAGE_W  = ADDR_W - WIN_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PAGE_W-1:0]  addrPage,
  input  logic               isMem,
  input  logic               addrStrobe,
  input  logic               dataStrobe,
  input  logic               extHold,
  input  logic               msTick,
  input  logic               regWe,
  input  logic [1:0]         regSel,
  input  logic [TABLE_W-1:0] regWdata,
  output logic               addrReady,
  output logic               dataReady
);
  strbCmd_t cmd;

  waitReadyCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrStrobe (addrStrobe),
    .dataStrobe (dataStrobe),
    .cmd        (cmd)
  );

  waitReadyPath #(
    .ADDR_W  (ADDR_W),
    .FIELD_W (FIELD_W),
    .REGIONS (REGIONS),
    .AWAIT_W (AWAIT_W),
    .WIN_W   (WIN_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .addrPage  (addrPage),
    .isMem     (isMem),
    .extHold   (extHold),
    .msTick    (msTick),
    .regWe     (regWe),
    .regSel    (regSel),
    .regWdata  (regWdata),
    .addrReady (addrReady),
    .dataReady (dataReady)
  );
endmodule

// File: rtl/waitReadyChk.sv
module waitReadyChk (
  input logic clk,
  input logic rstN,
  input logic addrStrobe,
  input logic dataStrobe,
  input logic extHold,
  input logic addrReady,
  input logic dataReady
);
  assert_aready_in_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    addrReady |-> addrStrobe);

  assert_aready_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (addrReady && addrStrobe) |=> (addrReady || !addrStrobe));

  assert_dready_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> (dataStrobe && !extHold));

  assert_dready_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && dataStrobe) |=> (dataReady || !dataStrobe || extHold));
endmodule

bind waitReadyGen waitReadyChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .addrStrobe (addrStrobe),
  .dataStrobe (dataStrobe),
  .extHold    (extHold),
  .addrReady  (addrReady),
  .dataReady  (dataReady)
);

// File: tb/waitReadyGen_tb.sv
module waitReadyGen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addrPage = '0;
  logic        isMem = 1'b1;
  logic        addrStrobe = 1'b0;
  logic        dataStrobe = 1'b0;
  logic        extHold = 1'b0;
  logic        msTick = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = '0;
  logic [15:0] regWdata = '0;
  logic        addrReady;
  logic        dataReady;

  int checks = 0;
  int errors = 0;
  logic [15:0] memT = 16'hFFFF;
  logic [15:0] ioT  = 16'hFFFF;
  logic [4:0]  ctl  = 5'b11000;

  always #4 clk = ~clk;

  waitReadyGen u_dut (
    .clk(clk), .rstN(rstN), .addrPage(addrPage), .isMem(isMem),
    .addrStrobe(addrStrobe), .dataStrobe(dataStrobe), .extHold(extHold),
    .msTick(msTick), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .addrReady(addrReady), .dataReady(dataReady)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    if (sel == 2'd0) memT = d;
    else if (sel == 2'd1) ioT = d;
    else if (sel == 2'd2) ctl = d[4:0];
  endtask

  function automatic int expLow(input logic [15:0] a, input logic m);
    int q = int'(a[15:14]);
    int f;
    logic lng;
    if (m) begin
      f = int'(memT[q*4 +: 4]);
      lng = ctl[1] && (q == 0);
    end else begin
      f = (ctl[0] || a[13:8] == 6'd0) ? int'(ioT[q*4 +: 4]) : 0;
      lng = ctl[2] && (a[14:8] == 7'd0);
    end
    return lng ? 2 * f : f;
  endfunction

  // msTick pulses in odd cycles of the strobe; long mode needs 2N low cycles.
  task automatic runData(input logic [15:0] a, input logic m, input string tag);
    int first = -1;
    int exp = expLow(a, m);
    logic bad = 1'b0;
    @(negedge clk);
    addrPage = a[15:8]; isMem = m; dataStrobe = 1'b1;
    for (int c = 0; c < 64; c++) begin
      msTick = (c % 2 == 1);
      #1;
      if (dataReady && first < 0) first = c;
      else if (!dataReady && first >= 0) bad = 1'b1;
      if (first >= 0 && c >= first + 2) break;
      @(negedge clk);
    end
    check(first == exp && !bad, tag, first, exp);
    @(negedge clk);
    dataStrobe = 1'b0; msTick = 1'b0;
    #1;
    check(dataReady == 1'b0, "R4 idle after strobe", int'(dataReady), 0);
  endtask

  task automatic runAddr(input int exp, input string tag);
    int first = -1;
    logic bad = 1'b0;
    @(negedge clk);
    addrStrobe = 1'b1;
    for (int c = 0; c < 10; c++) begin
      #1;
      if (addrReady && first < 0) first = c;
      else if (!addrReady && first >= 0) bad = 1'b1;
      if (first >= 0 && c >= first + 2) break;
      @(negedge clk);
    end
    check(first == exp && !bad, tag, first, exp);
    @(negedge clk);
    addrStrobe = 1'b0;
    #1;
    check(addrReady == 1'b0, "R2 idle after strobe", int'(addrReady), 0);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(addrReady == 1'b0 && dataReady == 1'b0, "R1 outputs idle after reset", int'({addrReady, dataReady}), 0);
    // R1 reset contents
    runAddr(3, "R1 address wait after reset");
    runData(16'h1234, 1'b1, "R1 memory wait after reset");
    runData(16'hC0F0, 1'b0, "R1 io wait after reset");

    // R2 address wait sweep
    for (int w = 0; w < 4; w++) begin
      wrReg(2'd2, 16'(w << 3));
      runAddr(w, "R2 address wait");
    end

    // R3 R4 memory quarters, two tables
    wrReg(2'd2, 16'h0000);
    foreach (memSet[i]) begin
      wrReg(2'd0, memSet[i]);
      for (int q = 0; q < 4; q++) begin
        runData(16'(q * 16'h4000), 1'b1, "R3 R4 memory quarter low");
        runData(16'(q * 16'h4000 + 16'h3FFF), 1'b1, "R3 R4 memory quarter high");
      end
    end

    // R5 R6 I/O window and full span
    wrReg(2'd1, 16'h7294);
    for (int s = 0; s < 2; s++) begin
      wrReg(2'd2, 16'(s));
      for (int q = 0; q < 4; q++) begin
        runData(16'(q * 16'h4000), 1'b0, s ? "R6 io span base" : "R5 io window base");
        runData(16'(q * 16'h4000 + 16'h00FF), 1'b0, s ? "R6 io span top" : "R5 io window top");
        runData(16'(q * 16'h4000 + 16'h0100), 1'b0, s ? "R6 io span outside" : "R5 io outside window");
        runData(16'(q * 16'h4000 + 16'h3F00), 1'b0, s ? "R6 io span far" : "R5 io far outside");
      end
    end

    // R7 long memory mode
    wrReg(2'd2, 16'h0002);
    foreach (longSet[i]) begin
      wrReg(2'd0, {12'h5A3, longSet[i]});
      runData(16'h0000, 1'b1, "R7 long memory base");
      runData(16'h3FFF, 1'b1, "R7 long memory top");
      runData(16'h4000, 1'b1, "R7 normal memory beside range");
    end

    // R8 long I/O mode
    wrReg(2'd2, 16'h0004);
    foreach (longSet[i]) begin
      wrReg(2'd1, {4'h2, longSet[i], 4'h5, longSet[i]});
      runData(16'h0000, 1'b0, "R8 long io 0000");
      runData(16'h00FF, 1'b0, "R8 long io 00FF");
      runData(16'h8000, 1'b0, "R8 long io 8000");
      runData(16'h80FF, 1'b0, "R8 long io 80FF");
      runData(16'h0100, 1'b0, "R8 io outside long range");
      runData(16'hC000, 1'b0, "R8 io normal quarter 3");
      runData(16'h4000, 1'b0, "R8 io normal quarter 1");
    end

    // R9 external hold: count of 4 runs through a hold, ready gated
    wrReg(2'd2, 16'h0000);
    wrReg(2'd0, 16'hFFF4);
    begin
      logic bad = 1'b0;
      @(negedge clk);
      addrPage = 8'h01; isMem = 1'b1; dataStrobe = 1'b1;
      for (int c = 0; c < 9; c++) begin
        extHold = (c == 1) || (c == 5) || (c == 6);
        #1;
        if (dataReady != ((c >= 4) && !extHold)) bad = 1'b1;
        @(negedge clk);
      end
      check(!bad, "R9 hold forces data ready low", int'(bad), 0);
      dataStrobe = 1'b0; extHold = 1'b0;
      #1;
      check(dataReady == 1'b0, "R9 idle after strobe", int'(dataReady), 0);
    end

    finishRun();
  end

  logic [15:0] memSet [2] = '{16'h3A50, 16'h1F2C};
  logic [3:0]  longSet [4] = '{4'h0, 4'h1, 4'h3, 4'h9};
endmodule